// File: doc/BRIEF.md
# SAR Conversion Controller

This block is the digital heart of a 12-bit successive-approximation converter. It watches three active-low control lines (convert request, read strobe and chip select), decides when a conversion begins, holds the track/hold stage for the length of the conversion, and walks the trial code one bit per clock using the comparator decision fed back from the analog side. The finished code is latched into a result register and driven on a 12-bit data bus. An output-enable qualifies the bus. One status pin reports the converter state in one of three hardwired ways.

The control lines are asynchronous to the conversion clock. Each one passes through a two-flop synchroniser before it is used. In the edge-started modes, a conversion begins on the clock after the three synchronised lines become low together. This happens on whichever line falls last, so one controller serves a free-running converter, a processor with wait states and a memory-mapped read that starts the next sample. In continuous mode the converter restarts by itself for as long as all three lines stay low.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `hold` is 0, `stat_n` is 1 and the result register `dout` is 0.
- R2: In modes 2'b01 and 2'b10, a conversion starts only when all three lines `conv_n`, `rd_n` and `cs_n` are low. The start is triggered by whichever line falls last, whether that is `conv_n`, `rd_n` or `cs_n`. Toggling `rd_n` and `cs_n` while `conv_n` stays high never starts one.
- R3: While a conversion is running, further start edges are ignored. Once it has finished, no new conversion follows until a fresh start edge arrives.
- R4: Inputs are driven between clock edges. `hold` rises on the third rising edge after the last line falls and stays high for exactly 12 clock periods. The result is latched on the 13th rising edge, counting the start edge as the first.
- R5: The first trial code is 12'h800. On each later edge, the current trial bit is kept if `cmp_in` is 1 and cleared if it is 0, and the next lower bit is set. `dout` is the two's-complement code with its MSB in bit 11: the final trial code with bit 11 inverted.
- R6: In interrupt mode (`mode` = 2'b10), `stat_n` falls on the edge where the result is latched. It returns high on the third rising edge after `rd_n` and `cs_n` become low together.
- R7: In busy mode (`mode` = 2'b01), `stat_n` is low exactly while `hold` is high. It returns high on the same edge as the result is latched.
- R8: In continuous mode (`mode` = 2'b00), while all three lines are low, conversions begin every 14 clocks with 2 track periods between them. Raising any one line lets the running conversion finish and then stops the sequence.
- R9: `dout_oe` is high exactly when `rd_n` and `cs_n` are both low. Throughout a conversion, `dout` keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Convert request, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| mode | input | 2 | Hardwired strap: 00 continuous, 01 busy, 10 interrupt, 11 treated as busy |
| cmp_in | input | 1 | Comparator decision for the current trial code (1 = keep bit) |
| hold | output | 1 | Track/hold control, 1 = hold |
| trial | output | 12 | Current trial code presented to the DAC |
| stat_n | output | 1 | Interrupt or busy status, active low |
| dout | output | 12 | Latched two's-complement result |
| dout_oe | output | 1 | Data bus enable |

## Verification
The assertions assume that `mode` is a strap that never changes once reset is released. They also assume that `cmp_in` is a function of the trial code presented in the previous cycle, which is how a settled DAC and comparator behave. The bench meets both assumptions. It changes `mode` only while the converter is idle, and it drives `cmp_in` combinationally from `trial` against a fixed target that is replaced only between conversions. The bench drives every control line on the falling clock edge, so the synchroniser latency is the same on every run and the cycle counts in the requirements can be checked exactly.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int W   = 12,
  parameter int ACQ = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_n,
  input  logic         rd_n,
  input  logic         cs_n,
  input  logic [1:0]   mode,
  input  logic         cmp_in,
  output logic         hold,
  output logic [W-1:0] trial,
  output logic         stat_n,
  output logic [W-1:0] dout,
  output logic         dout_oe
);
  localparam int IW = $clog2(W);
  localparam int GW = $clog2(ACQ + 1);
  localparam logic [1:0] MODE_CONT = 2'b00;
  localparam logic [1:0] MODE_INT  = 2'b10;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [2:0]    sync1, sync2;
  logic          go_q, rdx_q;
  logic          busy, int_f;
  logic [W-1:0]  sar, nxt, res;
  logic [IW-1:0] idx;
  logic [GW-1:0] gap;

  wire go     = ~|sync2;
  wire rd_act = ~sync2[1] & ~sync2[0];
  wire start  = (mode == MODE_CONT) ? (go && gap == '0) : (go && !go_q);
  wire last   = busy && idx == '0;

  always_comb begin
    nxt = sar;
    nxt[idx] = cmp_in;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '1;
      sync2 <= '1;
      go_q  <= 1'b0;
      rdx_q <= 1'b0;
      busy  <= 1'b0;
      sar   <= '0;
      idx   <= '0;
      res   <= '0;
      int_f <= 1'b0;
      gap   <= '0;
    end else begin
      sync1 <= {conv_n, rd_n, cs_n};
      sync2 <= sync1;
      go_q  <= go;
      rdx_q <= rd_act;
      if (gap != '0) gap <= gap - 1'b1;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sar  <= TOP_BIT;
          idx  <= IW'(W - 1);
        end
      end else begin
        sar <= nxt;
        if (idx == '0) begin
          busy <= 1'b0;
          res  <= nxt ^ TOP_BIT;
          gap  <= GW'(ACQ - 1);
        end else begin
          idx <= idx - 1'b1;
        end
      end
      if (last && mode == MODE_INT) int_f <= 1'b1;
      else if (rd_act && !rdx_q)    int_f <= 1'b0;
    end
  end

  assign hold    = busy;
  assign trial   = sar;
  assign dout    = res;
  assign dout_oe = ~rd_n & ~cs_n;
  assign stat_n  = (mode == MODE_INT) ? ~int_f : ~busy;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         hold,
  input logic [W-1:0] trial,
  input logic         stat_n,
  input logic [W-1:0] dout
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst)       hcnt <= '0;
    else if (hold) hcnt <= hcnt + 1'b1;
    else           hcnt <= '0;
  end

  a_r5_first_trial: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> trial == {1'b1, {(W-1){1'b0}}});

  a_r4_conv_len: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> hcnt == CW'(W));

  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    hcnt <= CW'(W));

  a_r9_data_frozen: assert property (@(posedge clk) disable iff (rst)
    hold && $past(hold) |-> $stable(dout));

  a_r7_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b10) && $rose(hold) |-> !stat_n);

  a_r6_int_on_done: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) && $fell(stat_n) |-> $fell(hold));

  a_r8_track_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> !$past(hold, 2));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .hold(hold),
  .trial(trial), .stat_n(stat_n), .dout(dout)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_n = 1'b1, rd_n = 1'b1, cs_n = 1'b1;
  logic [1:0] mode = 2'b01;
  logic [11:0] target = '0;
  logic cmp_in, hold, stat_n, dout_oe;
  logic [11:0] trial, dout;

  int checks = 0, fails = 0, cyc = 0;
  logic [11:0] exp_q[$];
  int rise_q[$];
  bit ph = 1'b0;
  int run = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign cmp_in = (trial <= target);

  sar_conv_ctrl u_dut (
    .clk(clk), .rst(rst), .conv_n(conv_n), .rd_n(rd_n), .cs_n(cs_n),
    .mode(mode), .cmp_in(cmp_in), .hold(hold), .trial(trial),
    .stat_n(stat_n), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (hold) run++;
      if (!ph && hold) rise_q.push_back(cyc);
      if (ph && !hold) begin
        check(run == 12, "R4 hold length", run, 12);
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected conversion", dout, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check(dout == e, "R5 result code", dout, e);
        end
      end
      if (!hold) run = 0;
      ph = hold;
    end
  end

  task automatic run_conv(input logic [11:0] tgt, input int last);
    logic [11:0] old;
    @(negedge clk);
    target = tgt;
    conv_n = (last == 0); rd_n = (last == 1); cs_n = (last == 2);
    tick(4);
    exp_q.push_back(tgt ^ 12'h800);
    old = dout;
    @(negedge clk);
    conv_n = 1'b0; rd_n = 1'b0; cs_n = 1'b0;
    tick(2);
    check(hold == 1'b0, "R4 latency early", hold, 0);
    tick(1);
    check(hold == 1'b1, "R4 hold rises", hold, 1);
    check(trial == 12'h800, "R5 first trial", trial, 12'h800);
    if (mode != 2'b10) check(stat_n == 1'b0, "R7 busy low", stat_n, 0);
    tick(11);
    check(hold == 1'b1, "R4 hold still high", hold, 1);
    check(dout == old, "R9 previous data", dout, old);
    tick(1);
    check(hold == 1'b0, "R4 hold released", hold, 0);
    if (mode != 2'b10) check(stat_n == 1'b1, "R7 busy high at end", stat_n, 1);
    else check(stat_n == 1'b0, "R6 interrupt asserted", stat_n, 0);
    @(negedge clk);
    conv_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    check(hold == 1'b0 && stat_n == 1'b1, "R1 reset outputs", {hold, stat_n}, 2'b01);
    check(dout == 12'h000, "R1 reset result", dout, 0);
    @(negedge clk) rst = 1'b0;
    tick(2);
    check(hold == 1'b0, "R1 idle after reset", hold, 0);
    check(dout_oe == 1'b0, "R9 bus disabled", dout_oe, 0);

    // R2: read alone with conv_n high never starts
    @(negedge clk) begin rd_n = 1'b0; cs_n = 1'b0; end
    tick(1);
    check(dout_oe == 1'b1, "R9 bus enabled on read", dout_oe, 1);
    tick(10);
    check(hold == 1'b0, "R2 no start with conv high", hold, 0);
    @(negedge clk) begin rd_n = 1'b1; cs_n = 1'b1; end
    tick(4);

    // R2/R5: each line as the last one, several codes
    run_conv(12'h5A3, 0);
    run_conv(12'h000, 1);
    run_conv(12'hFFF, 2);
    run_conv(12'h800, 0);
    run_conv(12'h7FF, 1);

    // R3: retrigger during a conversion is ignored
    @(negedge clk) begin target = 12'h123; rd_n = 1'b0; cs_n = 1'b0; end
    tick(4);
    exp_q.push_back(12'h123 ^ 12'h800);
    @(negedge clk) conv_n = 1'b0;
    tick(5);
    @(negedge clk) conv_n = 1'b1;
    tick(2);
    @(negedge clk) conv_n = 1'b0;
    tick(25);
    check(hold == 1'b0, "R3 no restart", hold, 0);
    check(exp_q.size() == 0, "R3 single conversion", exp_q.size(), 0);
    @(negedge clk) begin conv_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1; end
    tick(4);

    // R6: interrupt mode
    mode = 2'b10;
    tick(2);
    run_conv(12'hA5C, 1);
    check(stat_n == 1'b0, "R6 interrupt held until read", stat_n, 0);
    @(negedge clk) begin rd_n = 1'b0; cs_n = 1'b0; end
    tick(2);
    check(stat_n == 1'b0, "R6 not cleared early", stat_n, 0);
    tick(1);
    check(stat_n == 1'b1, "R6 cleared by read", stat_n, 1);
    check(hold == 1'b0, "R2 read clears without starting", hold, 0);
    @(negedge clk) begin rd_n = 1'b1; cs_n = 1'b1; end
    tick(4);

    // R8: continuous mode
    mode = 2'b00;
    rise_q.delete();
    @(negedge clk) target = 12'h3C5;
    repeat (3) exp_q.push_back(12'h3C5 ^ 12'h800);
    @(negedge clk) begin conv_n = 1'b0; rd_n = 1'b0; cs_n = 1'b0; end
    while (rise_q.size() < 3) tick(1);
    @(negedge clk) cs_n = 1'b1;
    tick(40);
    check(rise_q.size() == 3, "R8 stops after raise", rise_q.size(), 3);
    if (rise_q.size() >= 3) begin
      check(rise_q[1] - rise_q[0] == 14, "R8 period", rise_q[1] - rise_q[0], 14);
      check(rise_q[2] - rise_q[1] == 14, "R8 period", rise_q[2] - rise_q[1], 14);
    end
    check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    check(hold == 1'b0, "R8 idle after stop", hold, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule